// File: doc/BRIEF.md
# Block-Handshake Dual-Clock Sample FIFO

This block carries a stream of 16-bit samples from a producer clock domain into a consumer clock domain. Its storage is split into a ring of equal memory blocks. The producer fills one block completely, hands it over, and moves to the next. The consumer takes only whole blocks. It drains a block word by word, hands it back, and moves on.

The two domains do not exchange word pointers. Each block has two single-bit toggles. A fill toggle is owned by the write side and an ack toggle is owned by the read side. Each toggle reaches the opposite domain through a two-flop synchronizer. A block is readable while its synchronized fill toggle differs from the reader's own ack toggle. A block is writable again only once the reader's ack toggle, seen through the synchronizer, equals the writer's fill toggle.

The write side reports free space and a one-cycle error pulse for a write while no block is free. The read side presents a registered head word with a valid flag. It also gives a one-cycle error pulse for a read request while nothing is valid.

Top module: `blk_cdc_fifo`

## Requirements
- R1: After reset in both domains, wr_ready is 1, rd_valid is 0, and wr_err and rd_err are 0.
- R2: Words of a block that is only partly written are never presented: rd_valid stays 0 until the last word of the block has been written.
- R3: Once the last word of a block is written, rd_valid rises within four read-clock cycles. The words then appear on rd_data in the order in which they were written.
- R4: With rd_valid high, a high rd_next at a read-clock edge presents the next word at that edge. Without rd_next, rd_valid and rd_data hold. Holding rd_next high while words are valid gives one word per cycle, with no gap across a block boundary when the next block is already full.
- R5: When every block holds unread data, wr_ready is 0. A write attempted then raises wr_err for exactly the next write-clock cycle, and the word is discarded and never read out. A write accepted with wr_ready high leaves wr_err at 0.
- R6: rd_next while rd_valid is 0 raises rd_err for exactly the next read-clock cycle and leaves the read position unchanged.
- R7: A full FIFO does not regain wr_ready while any word of its oldest block is unread. wr_ready returns within four write-clock cycles after that block's last word is consumed. wr_ready never falls without a write.
- R8: Blocks are used in ring order, and the block index wraps from the last block back to block 0 on both sides with data order preserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_en | input | 1 | Store wr_data at this write-clock edge |
| wr_data | input | DATA_W | Sample to store |
| wr_ready | output | 1 | Current block has free space |
| wr_err | output | 1 | Previous cycle attempted a write with no free space |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_next | input | 1 | Consume the presented word at this read-clock edge |
| rd_data | output | DATA_W | Presented head word |
| rd_valid | output | 1 | rd_data holds an unread word |
| rd_err | output | 1 | Previous cycle requested a word while none was valid |

## Verification
Each result has its own due time. The error pulses are due one edge after the offending request. A new head word is due at the edge that consumes the old one. A block hand-over takes two synchronizer stages plus one register, so it is due within four cycles of the destination clock.

Inputs are driven on falling edges of their own clock, and outputs are sampled on later falling edges. The single-edge results are therefore read at the first falling edge after the edge that produces them. The hand-over results are polled over a bounded window of falling edges, matched to the synchronizer depth. Absence results, such as a partial block staying invisible or a full FIFO staying not ready, are held and sampled over windows longer than any hand-over delay.

// File: rtl/blk_cdc_fifo_pkg.sv
package blk_cdc_fifo_pkg;
    // Default geometry: 16-bit samples, 512-byte blocks, four blocks
    localparam int unsigned DEF_DATA_W    = 16;
    localparam int unsigned DEF_BLK_WORDS = 256;
    localparam int unsigned DEF_NUM_BLKS  = 4;

    // Width of an index counting 0 .. n-1, at least one bit
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/blk_cdc_sync2.sv
module blk_cdc_sync2 #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/blk_cdc_ram.sv
module blk_cdc_ram #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 1024,
    localparam int unsigned AW    = blk_cdc_fifo_pkg::idx_w(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/blk_cdc_wr_ctrl.sv
module blk_cdc_wr_ctrl #(
    parameter int unsigned NUM_BLKS  = 4,
    parameter int unsigned BLK_WORDS = 256,
    localparam int unsigned BI_W     = blk_cdc_fifo_pkg::idx_w(NUM_BLKS),
    localparam int unsigned WI_W     = blk_cdc_fifo_pkg::idx_w(BLK_WORDS),
    localparam int unsigned AW       = blk_cdc_fifo_pkg::idx_w(NUM_BLKS * BLK_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [NUM_BLKS-1:0] ack_sync,
    output logic [NUM_BLKS-1:0] fill_tog,
    output logic                ready,
    output logic                err,
    output logic                mem_we,
    output logic [AW-1:0]       mem_waddr
);
    localparam logic [BI_W-1:0] LAST_BLK  = BI_W'(NUM_BLKS - 1);
    localparam logic [WI_W-1:0] LAST_WORD = WI_W'(BLK_WORDS - 1);

    typedef struct packed {
        logic [BI_W-1:0]     blk;
        logic [WI_W-1:0]     word;
        logic [NUM_BLKS-1:0] tog;
        logic                err;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      free_w;

    always_comb begin
        st_d   = st_q;
        st_d.err = 1'b0;
        free_w = (st_q.tog[st_q.blk] == ack_sync[st_q.blk]);
        mem_we = 1'b0;
        if (wr_en) begin
            if (free_w) begin
                mem_we = 1'b1;
                if (st_q.word == LAST_WORD) begin
                    st_d.word          = '0;
                    st_d.tog[st_q.blk] = ~st_q.tog[st_q.blk];
                    st_d.blk           = (st_q.blk == LAST_BLK) ? '0 : st_q.blk + 1'b1;
                end else begin
                    st_d.word = st_q.word + 1'b1;
                end
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fill_tog  = st_q.tog;
    assign ready     = free_w;
    assign err       = st_q.err;
    assign mem_waddr = AW'(st_q.blk) * AW'(BLK_WORDS) + AW'(st_q.word);
endmodule

// File: rtl/blk_cdc_rd_ctrl.sv
module blk_cdc_rd_ctrl #(
    parameter int unsigned NUM_BLKS  = 4,
    parameter int unsigned BLK_WORDS = 256,
    localparam int unsigned BI_W     = blk_cdc_fifo_pkg::idx_w(NUM_BLKS),
    localparam int unsigned WI_W     = blk_cdc_fifo_pkg::idx_w(BLK_WORDS),
    localparam int unsigned AW       = blk_cdc_fifo_pkg::idx_w(NUM_BLKS * BLK_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_next,
    input  logic [NUM_BLKS-1:0] fill_sync,
    output logic [NUM_BLKS-1:0] ack_tog,
    output logic                valid,
    output logic                err,
    output logic [AW-1:0]       mem_raddr
);
    localparam logic [BI_W-1:0] LAST_BLK  = BI_W'(NUM_BLKS - 1);
    localparam logic [WI_W-1:0] LAST_WORD = WI_W'(BLK_WORDS - 1);

    typedef struct packed {
        logic [BI_W-1:0]     blk;
        logic [WI_W-1:0]     word;
        logic [NUM_BLKS-1:0] tog;
        logic                valid;
        logic                err;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (rd_next) begin
            if (st_q.valid) begin
                if (st_q.word == LAST_WORD) begin
                    st_d.word          = '0;
                    st_d.tog[st_q.blk] = ~st_q.tog[st_q.blk];
                    st_d.blk           = (st_q.blk == LAST_BLK) ? '0 : st_q.blk + 1'b1;
                end else begin
                    st_d.word = st_q.word + 1'b1;
                end
            end else begin
                st_d.err = 1'b1;
            end
        end
        // Head word is valid while the block it lies in is owned by the reader
        st_d.valid = (fill_sync[st_d.blk] != st_d.tog[st_d.blk]);
        mem_raddr  = AW'(st_d.blk) * AW'(BLK_WORDS) + AW'(st_d.word);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_tog = st_q.tog;
    assign valid   = st_q.valid;
    assign err     = st_q.err;
endmodule

// File: rtl/blk_cdc_fifo.sv
module blk_cdc_fifo #(
    parameter int unsigned DATA_W    = blk_cdc_fifo_pkg::DEF_DATA_W,
    parameter int unsigned BLK_WORDS = blk_cdc_fifo_pkg::DEF_BLK_WORDS,
    parameter int unsigned NUM_BLKS  = blk_cdc_fifo_pkg::DEF_NUM_BLKS
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              wr_err,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_next,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_err
);
    localparam int unsigned DEPTH = NUM_BLKS * BLK_WORDS;
    localparam int unsigned AW    = blk_cdc_fifo_pkg::idx_w(DEPTH);

    logic [NUM_BLKS-1:0] fill_tog, fill_sync;
    logic [NUM_BLKS-1:0] ack_tog, ack_sync;
    logic                mem_we;
    logic [AW-1:0]       mem_waddr, mem_raddr;

    blk_cdc_wr_ctrl #(.NUM_BLKS(NUM_BLKS), .BLK_WORDS(BLK_WORDS)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .ack_sync(ack_sync),
        .fill_tog(fill_tog), .ready(wr_ready), .err(wr_err),
        .mem_we(mem_we), .mem_waddr(mem_waddr)
    );

    blk_cdc_sync2 #(.W(NUM_BLKS)) u_fill_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .async_in(fill_tog), .sync_out(fill_sync)
    );

    blk_cdc_sync2 #(.W(NUM_BLKS)) u_ack_sync (
        .clk(wr_clk), .rst_n(wr_rst_n), .async_in(ack_tog), .sync_out(ack_sync)
    );

    blk_cdc_rd_ctrl #(.NUM_BLKS(NUM_BLKS), .BLK_WORDS(BLK_WORDS)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_next(rd_next), .fill_sync(fill_sync),
        .ack_tog(ack_tog), .valid(rd_valid), .err(rd_err), .mem_raddr(mem_raddr)
    );

    blk_cdc_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
        .rclk(rd_clk), .raddr(mem_raddr), .rdata(rd_data)
    );
endmodule

// File: rtl/blk_cdc_fifo_chk.sv
module blk_cdc_fifo_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_en,
    input logic              wr_ready,
    input logic              wr_err,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_next,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_err
);
    p_full_write_err_r5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && !wr_ready) |=> wr_err);

    p_good_write_no_err_r5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && wr_ready) |=> !wr_err);

    p_ready_needs_write_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_ready && !wr_en) |=> wr_ready);

    p_empty_read_err_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_next && !rd_valid) |=> rd_err);

    p_err_has_cause_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_err |-> $past(rd_next && !rd_valid));

    p_head_holds_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_valid && !rd_next) |=> (rd_valid && $stable(rd_data)));
endmodule

bind blk_cdc_fifo blk_cdc_fifo_chk #(.DATA_W(DATA_W)) u_chk (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_ready(wr_ready),
    .wr_err(wr_err), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_next(rd_next),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err)
);

// File: tb/blk_cdc_fifo_bench.sv
module blk_cdc_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;
    localparam int DW = 16;
    localparam int B  = 8;
    localparam int N  = 4;

    // Table: {read with gaps, base value}
    localparam logic [16:0] VEC [4] = '{
        {1'b0, 16'h0100}, {1'b1, 16'h2200}, {1'b0, 16'hFFFC}, {1'b1, 16'h5A50}
    };

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst_n = 0, rd_rst_n = 0;
    logic wr_en = 0, rd_next = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic wr_ready, wr_err, rd_valid, rd_err;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

    blk_cdc_fifo #(.DATA_W(DW), .BLK_WORDS(B), .NUM_BLKS(N)) u_blk_cdc_fifo (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ready(wr_ready), .wr_err(wr_err), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .rd_next(rd_next), .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_words(input logic [DW-1:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en   = 1'b1;
            wr_data = base + DW'(i);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // Reads n words expecting base+i; reports stalls after the first word
    task automatic read_words(input logic [DW-1:0] base, input int n, input bit gap,
                              input string req, output int stalls);
        int got = 0;
        int tmo = 0;
        stalls = 0;
        rd_next = 1'b0;
        while (got < n && tmo < 200) begin
            @(negedge rd_clk);
            if (rd_next && gap) begin
                rd_next = 1'b0;
            end else if (rd_valid) begin
                check(rd_data == base + DW'(got), req, rd_data, base + DW'(got));
                got++;
                rd_next = 1'b1;
            end else begin
                rd_next = 1'b0;
                tmo++;
                if (got > 0) stalls++;
            end
        end
        check(got == n, req, got, n);
        @(negedge rd_clk);
        rd_next = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int st, wt;
        repeat (4) @(negedge wr_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        repeat (2) @(negedge rd_clk);

        // R1 reset state
        check(wr_ready == 1, "R1 wr_ready", wr_ready, 1);
        check(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
        check(wr_err == 0 && rd_err == 0, "R1 errors", {wr_err, rd_err}, 0);

        // R6 read on empty
        @(negedge rd_clk); rd_next = 1;
        @(negedge rd_clk); rd_next = 0;
        check(rd_err == 1, "R6 err pulse", rd_err, 1);
        @(negedge rd_clk);
        check(rd_err == 0, "R6 err single", rd_err, 0);

        // R2 partial block invisible, R3 latency
        write_words(16'h0A00, B - 1);
        repeat (10) begin
            @(negedge rd_clk);
            check(rd_valid == 0, "R2 partial", rd_valid, 0);
        end
        write_words(16'h0A00 + DW'(B - 1), 1);
        wt = 0;
        while (!rd_valid && wt < 10) begin @(negedge rd_clk); wt++; end
        check(wt <= 4, "R3 hand-over cycles", wt, 4);
        read_words(16'h0A00, B, 0, "R3 order", st);

        // R6 pointer unchanged after the earlier empty read: order already checked above
        // Table walk: blocks 1,2,3 then wrap to 0 (R8)
        for (int v = 0; v < 4; v++) begin
            write_words(VEC[v][15:0], B);
            read_words(VEC[v][15:0], B, VEC[v][16], "R8 ring", st);
        end

        // R4 streaming across a block boundary
        write_words(16'h3000, 2 * B);
        read_words(16'h3000, 2 * B, 0, "R4 stream", st);
        check(st == 0, "R4 no gap", st, 0);

        // R5 full FIFO
        write_words(16'h1000, N * B);
        check(wr_ready == 0, "R5 full ready", wr_ready, 1'b0);
        @(negedge wr_clk); wr_en = 1; wr_data = 16'hDEAD;
        @(negedge wr_clk); wr_en = 0;
        check(wr_err == 1, "R5 err pulse", wr_err, 1);
        @(negedge wr_clk);
        check(wr_err == 0, "R5 err single", wr_err, 0);

        // R7 release only after whole block drained
        read_words(16'h1000, B - 1, 0, "R7 drain", st);
        repeat (8) @(negedge wr_clk);
        check(wr_ready == 0, "R7 early release", wr_ready, 0);
        read_words(16'h1000 + DW'(B - 1), 1, 0, "R7 drain", st);
        wt = 0;
        while (!wr_ready && wt < 10) begin @(negedge wr_clk); wt++; end
        check(wt <= 4, "R7 release cycles", wt, 4);

        // R5 rejected word never appears
        read_words(16'h1000 + DW'(B), (N - 1) * B, 0, "R5 discard", st);
        repeat (8) @(negedge rd_clk);
        check(rd_valid == 0, "R5 drained", rd_valid, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule